// File: doc/BRIEF.md
# SDRAM Command Controller

This block sits between a simple host port and a four-bank synchronous DRAM with a 16-bit data bus. It takes one-word read and write requests on a valid/ready handshake. Each request carries a flat word address, write data and a byte-enable pair. The block turns every request into the command sequence the memory needs: it opens the row, issues the column access with auto-precharge, and waits out the recovery time. Read data comes back on a one-cycle valid strobe.

After reset the block waits a programmable power-up time. It then precharges all banks, issues two refreshes and loads the mode register. The mode word is built from the CAS latency, burst length and wrap-order parameters. Only after that does it accept host traffic. From then on a free-running interval timer asks for one auto-refresh about every 7.8 µs. A refresh request that is pending is served before any new host request, once the access in flight has finished.

Every access closes its row, so all banks are idle between operations. A host word moves on the first beat of the programmed burst. The remaining write beats are masked, and the remaining read beats are ignored.

Top module: `sdr_ctrl`

## Requirements
- R1: The command pins {cs_n, ras_n, cas_n, we_n} use these encodings: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, LOAD MODE 0000. While reset is asserted and during the power-up wait, the pins show NOP, and req_ready_o and rd_valid_o are low.
- R2: At least INIT_CYCLES cycles after reset, the controller issues, in this order: PRECHARGE with address bit 10 set, REFRESH, REFRESH, LOAD MODE. req_ready_o stays low until this sequence has completed.
- R3: The LOAD MODE command carries bank 0 and a mode word built as follows. Bits [2:0] hold log2 of the burst length (1→0, 2→1, 4→2, 8→3). Bit 3 is 1 for interleaved wrap order. Bits [6:4] hold the CAS latency. All other bits are 0.
- R4: The host address splits as bank = [23:22], row = [21:9], column = [8:0]. An accepted request first produces ACTIVE with that bank and row. The cycle after ACTIVE carries no command. Exactly T_RCD cycles after ACTIVE comes READ or WRITE, with the column on address bits [8:0] and address bit 10 set for auto-precharge.
- R5: The WRITE cycle drives the write data with the output enable high and dqm = ~be (dqm bit 1 masks bits 15:8). The following BURST_LEN-1 cycles keep the bus driven with dqm = 11.
- R6: sd_dq_i is sampled exactly CAS_LAT cycles after the READ command. The sampled word appears on rd_data_o with a one-cycle rd_valid_o in the next cycle, and results return in request order.
- R7: After initialization, REFRESH commands repeat at intervals of no more than REF_INTERVAL = REF_PERIOD_NS*1000/CLK_PERIOD_PS cycles plus the length of one access, whether the host is idle or busy.
- R8: While a refresh is pending, req_ready_o is low. Under continuous host traffic the refresh is issued before the next request is accepted.
- R9: No command follows a REFRESH for T_RFC cycles, and none follows a PRECHARGE for T_RP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request accepted this cycle when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 24 | Word address {bank, row, column} |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables for the write (bit 1 = upper byte) |
| rd_valid_o | output | 1 | Read data strobe |
| rd_data_o | output | 16 | Read data |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | 2 | Bank select |
| sd_addr_o | output | 13 | Row / column / mode address |
| sd_dqm_o | output | 2 | Data mask, 1 masks the byte |
| sd_dq_o | output | 16 | Data toward the memory |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dq_i | input | 16 | Data from the memory |

## Verification
The bench models the memory from the command pins alone. Outside the one cycle that holds real read data, it drives a distinct junk word on the data bus. A capture stage with the CAS latency off by one therefore returns junk, and the scoreboard reports a wrong word. Partial byte enables, and the masked trailing write beats, are checked both on the pins and through later read-back: a wrong mask polarity or an unmasked beat shows up as corrupted neighbouring data. Refresh spacing is measured under back-to-back host traffic and again with the host idle. A controller that lets host requests win over refresh, or that loses the pending flag, leaves a gap longer than one interval plus one access.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  function automatic logic [12:0] mode_word(input int cas_lat, input int burst_len,
                                            input bit interleave);
    logic [12:0] w;
    w = '0;
    w[2:0] = 3'($clog2(burst_len));
    w[3]   = interleave;
    w[6:4] = 3'(cas_lat);
    return w;
  endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int INTERVAL = 975
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CNT_W = $clog2(INTERVAL + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(INTERVAL - 1);
      pend_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= CNT_W'(INTERVAL - 1);
      pend_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int CAS_LAT = 3,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_cmd_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [CAS_LAT-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      sr_q    <= {sr_q[CAS_LAT-2:0], rd_cmd_i};
      valid_o <= sr_q[CAS_LAT-1];
      if (sr_q[CAS_LAT-1]) data_o <= dq_i;
    end
  end
endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
  import sdr_pkg::*;
#(
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int BANK_W      = 2,
  parameter int DATA_W      = 16,
  parameter int MASK_W      = 2,
  parameter int CAS_LAT     = 3,
  parameter int BURST_LEN   = 4,
  parameter int T_RCD       = 2,
  parameter int T_RP        = 2,
  parameter int T_RFC       = 8,
  parameter int T_WR        = 2,
  parameter int T_MRD       = 2,
  parameter int INIT_CYCLES = 12500,
  parameter logic [ROW_W-1:0] MODE = '0,
  localparam int AW = BANK_W + ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [MASK_W-1:0] req_be_i,
  input  logic              ref_pend_i,
  output logic              ref_ack_o,
  output sdr_cmd_e          cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [MASK_W-1:0] dqm_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int RD_WAIT  = CAS_LAT + BURST_LEN + T_RP - 1;
  localparam int WR_WAIT  = BURST_LEN + T_WR + T_RP - 2;
  localparam int WAIT_MAX = INIT_CYCLES + RD_WAIT + WR_WAIT + T_RFC + T_MRD;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int BEAT_W   = $clog2(BURST_LEN + 1);

  typedef enum logic [2:0] {
    S_POWER, S_INIT_REF1, S_INIT_REF2, S_LMR, S_IDLE, S_ACCESS
  } state_e;

  state_e              state_q;
  logic [WAIT_W-1:0]   wait_q;
  logic [BEAT_W-1:0]   beat_q;
  logic                we_q;
  logic [COL_W-1:0]    col_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [MASK_W-1:0]   be_q;
  logic [ROW_W-1:0]    col_addr;
  logic [ROW_W-1:0]    pre_all;

  assign req_ready_o = (state_q == S_IDLE) && (wait_q == '0) && !ref_pend_i;

  always_comb begin
    col_addr = '0;
    col_addr[COL_W-1:0] = col_q;
    col_addr[10] = 1'b1;     // auto-precharge
    pre_all = '0;
    pre_all[10] = 1'b1;      // all banks
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_POWER;
      wait_q    <= WAIT_W'(INIT_CYCLES);
      beat_q    <= '0;
      we_q      <= 1'b0;
      col_q     <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      cmd_o     <= CMD_NOP;
      ba_o      <= '0;
      addr_o    <= '0;
      dqm_o     <= '0;
      dq_o      <= '0;
      dq_oe_o   <= 1'b0;
      ref_ack_o <= 1'b0;
    end else begin
      cmd_o     <= CMD_NOP;
      ref_ack_o <= 1'b0;
      dq_oe_o   <= 1'b0;
      dqm_o     <= '0;
      if (beat_q != '0) begin    // trailing write beats, masked
        beat_q  <= beat_q - 1'b1;
        dq_oe_o <= 1'b1;
        dqm_o   <= '1;
      end
      if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else begin
        unique case (state_q)
          S_POWER: begin
            cmd_o   <= CMD_PRE;
            addr_o  <= pre_all;
            wait_q  <= WAIT_W'(T_RP - 1);
            state_q <= S_INIT_REF1;
          end
          S_INIT_REF1, S_INIT_REF2: begin
            cmd_o   <= CMD_REF;
            wait_q  <= WAIT_W'(T_RFC - 1);
            state_q <= (state_q == S_INIT_REF1) ? S_INIT_REF2 : S_LMR;
          end
          S_LMR: begin
            cmd_o   <= CMD_LMR;
            ba_o    <= '0;
            addr_o  <= MODE;
            wait_q  <= WAIT_W'(T_MRD - 1);
            state_q <= S_IDLE;
          end
          S_IDLE: begin
            if (ref_pend_i) begin
              cmd_o     <= CMD_REF;
              ref_ack_o <= 1'b1;
              wait_q    <= WAIT_W'(T_RFC - 1);
            end else if (req_valid_i) begin
              cmd_o   <= CMD_ACT;
              ba_o    <= req_addr_i[AW-1 -: BANK_W];
              addr_o  <= req_addr_i[COL_W +: ROW_W];
              we_q    <= req_we_i;
              col_q   <= req_addr_i[COL_W-1:0];
              wdata_q <= req_wdata_i;
              be_q    <= req_be_i;
              wait_q  <= WAIT_W'(T_RCD - 1);
              state_q <= S_ACCESS;
            end
          end
          S_ACCESS: begin
            addr_o  <= col_addr;
            state_q <= S_IDLE;
            if (we_q) begin
              cmd_o   <= CMD_WR;
              dq_o    <= wdata_q;
              dqm_o   <= ~be_q;
              dq_oe_o <= 1'b1;
              beat_q  <= BEAT_W'(BURST_LEN - 1);
              wait_q  <= WAIT_W'(WR_WAIT);
            end else begin
              cmd_o  <= CMD_RD;
              wait_q <= WAIT_W'(RD_WAIT);
            end
          end
          default: state_q <= S_POWER;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdr_ctrl.sv
module sdr_ctrl
  import sdr_pkg::*;
#(
  parameter int ROW_W           = 13,
  parameter int COL_W           = 9,
  parameter int DATA_W          = 16,
  parameter int CAS_LAT         = 3,
  parameter int BURST_LEN       = 4,
  parameter bit WRAP_INTERLEAVE = 1'b0,
  parameter int T_RCD           = 2,
  parameter int T_RP            = 2,
  parameter int T_RFC           = 8,
  parameter int T_WR            = 2,
  parameter int T_MRD           = 2,
  parameter int INIT_CYCLES     = 12500,
  parameter int CLK_PERIOD_PS   = 8000,
  parameter int REF_PERIOD_NS   = 7800,
  localparam int BANK_W = 2,
  localparam int AW     = BANK_W + ROW_W + COL_W,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [MASK_W-1:0] req_be_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [BANK_W-1:0] sd_ba_o,
  output logic [ROW_W-1:0]  sd_addr_o,
  output logic [MASK_W-1:0] sd_dqm_o,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe_o,
  input  logic [DATA_W-1:0] sd_dq_i
);
  localparam int REF_INTERVAL = REF_PERIOD_NS * 1000 / CLK_PERIOD_PS;
  localparam logic [ROW_W-1:0] MODE =
    ROW_W'(mode_word(CAS_LAT, BURST_LEN, WRAP_INTERLEAVE));

  sdr_cmd_e cmd;
  logic     ref_pend;
  logic     ref_ack;

  assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;

  sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (ref_ack),
    .pend_o(ref_pend)
  );

  sdr_cmd_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .MASK_W(MASK_W),
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_WR(T_WR), .T_MRD(T_MRD), .INIT_CYCLES(INIT_CYCLES), .MODE(MODE)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_we_i   (req_we_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .req_be_i   (req_be_i),
    .ref_pend_i (ref_pend),
    .ref_ack_o  (ref_ack),
    .cmd_o      (cmd),
    .ba_o       (sd_ba_o),
    .addr_o     (sd_addr_o),
    .dqm_o      (sd_dqm_o),
    .dq_o       (sd_dq_o),
    .dq_oe_o    (sd_dq_oe_o)
  );

  sdr_rd_capture #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_cmd_i(cmd == CMD_RD),
    .dq_i    (sd_dq_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/sdr_ctrl_chk.sv
module sdr_ctrl_chk
  import sdr_pkg::*;
#(
  parameter int CAS_LAT = 3,
  parameter int MASK_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        cmd_i,
  input logic              a10_i,
  input logic [MASK_W-1:0] dqm_i,
  input logic              dq_oe_i,
  input logic              rd_valid_i,
  input logic              ready_i,
  input logic              ref_pend_i
);
  assert_autopre_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RD || cmd_i == CMD_WR) |-> a10_i);

  assert_act_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ACT) |=> (cmd_i == CMD_NOP));

  assert_wr_tail_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_i && cmd_i != CMD_WR) |-> (dqm_i == '1));

  assert_cas_lat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |-> $past(cmd_i == CMD_RD, CAS_LAT + 1));

  assert_ref_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pend_i |-> !ready_i);

  assert_ref_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_REF) |=> (cmd_i == CMD_NOP));
endmodule

bind sdr_ctrl sdr_ctrl_chk #(.CAS_LAT(CAS_LAT), .MASK_W(MASK_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_i     ({sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o}),
  .a10_i     (sd_addr_o[10]),
  .dqm_i     (sd_dqm_o),
  .dq_oe_i   (sd_dq_oe_o),
  .rd_valid_i(rd_valid_o),
  .ready_i   (req_ready_o),
  .ref_pend_i(ref_pend)
);

// File: tb/sdr_ctrl_bench.sv
module sdr_ctrl_bench;
  localparam int CLK_PERIOD = 8;
  localparam int CAS_LAT = 3, BURST_LEN = 4, T_RCD = 2, T_RP = 2, T_RFC = 8;
  localparam int INIT_CYCLES = 1500;
  localparam int REF_INT = 7800 * 1000 / 8000;
  localparam int SLACK = T_RFC + T_RCD + CAS_LAT + BURST_LEN + T_RP + 4;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_LMR = 4'b0000;
  localparam logic [12:0] EXP_MODE = 13'((CAS_LAT << 4) | $clog2(BURST_LEN));

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic rd_valid;
  logic [15:0] rd_data;
  logic cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [1:0] ba, dqm;
  logic [12:0] sd_addr;
  logic [15:0] dq_o, dq_i = 16'hBAD0;

  int vec = 0, miss = 0;
  logic [15:0] exp_q[$];
  logic [15:0] shadow[logic [23:0]];
  logic [15:0] mem[logic [23:0]];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdr_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_sdr_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n), .sd_we_n_o(we_n),
    .sd_ba_o(ba), .sd_addr_o(sd_addr), .sd_dqm_o(dqm), .sd_dq_o(dq_o),
    .sd_dq_oe_o(dq_oe), .sd_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
  endtask

  // memory model + pin monitor, sampled mid-cycle
  int cyc, init_idx, last_t, act_t, rd_t, last_ref_t, ref_cnt, wbeats, rd_cd;
  logic [3:0] last_cmd;
  logic [12:0] open_row[4];
  logic [1:0] e_bank;
  logic [12:0] e_row;
  logic [8:0] e_col;
  logic [15:0] e_wdata, rd_word;
  logic [1:0] e_be;

  always @(negedge clk) begin
    logic [3:0] c;
    logic [23:0] key;
    c = {cs_n, ras_n, cas_n, we_n};
    if (!rst_n) begin
      cyc = 0; init_idx = 0; last_t = 0; act_t = 0; rd_t = 0; last_ref_t = -1;
      ref_cnt = 0; wbeats = 0; rd_cd = 0; last_cmd = C_NOP;
    end else begin
      cyc++;
      dq_i = 16'hBAD0 | 16'(cyc & 15);
      if (rd_cd > 0) begin
        rd_cd--;
        if (rd_cd == 0) dq_i = rd_word;
      end
      if (init_idx < 4 && req_ready) chk(0, "R2", "ready before init done", 1, 0);
      if (req_valid && req_ready) begin
        e_bank = req_addr[23:22]; e_row = req_addr[21:9]; e_col = req_addr[8:0];
        e_wdata = req_wdata; e_be = req_be;
      end
      if (c != C_NOP) begin
        if (last_cmd == C_REF) chk(cyc - last_t >= T_RFC, "R9", "gap after REFRESH", cyc - last_t, T_RFC);
        if (last_cmd == C_PRE) chk(cyc - last_t >= T_RP, "R9", "gap after PRECHARGE", cyc - last_t, T_RP);
        case (c)
          C_PRE: begin
            chk(init_idx == 0 && sd_addr[10] && cyc >= INIT_CYCLES, "R2", "precharge-all", cyc, INIT_CYCLES);
            init_idx = 1;
          end
          C_REF: begin
            if (init_idx < 4) begin
              chk(init_idx == 1 || init_idx == 2, "R2", "init refresh order", init_idx, 1);
              init_idx++;
            end else begin
              chk(cyc - last_ref_t <= REF_INT + SLACK, "R7_R8", "refresh spacing", cyc - last_ref_t, REF_INT + SLACK);
              ref_cnt++;
            end
            last_ref_t = cyc;
          end
          C_LMR: begin
            chk(init_idx == 3, "R2", "mode load order", init_idx, 3);
            chk(sd_addr == EXP_MODE && ba == 2'b00, "R3", "mode word", {ba, sd_addr}, EXP_MODE);
            init_idx = 4;
          end
          C_ACT: begin
            chk(ba == e_bank && sd_addr == e_row, "R4", "active bank/row", {ba, sd_addr}, {e_bank, e_row});
            act_t = cyc;
            open_row[ba] = sd_addr;
          end
          C_RD, C_WR: begin
            chk(cyc - act_t == T_RCD, "R4", "ACTIVE to column gap", cyc - act_t, T_RCD);
            chk(sd_addr[10] && sd_addr[8:0] == e_col, "R4", "column/auto-precharge", sd_addr, {4'b0010, e_col});
            key = {ba, open_row[ba], sd_addr[8:0]};
            if (c == C_WR) begin
              chk(dq_oe && dq_o == e_wdata && dqm == ~e_be, "R5", "write beat", {dq_oe, dqm, dq_o}, {1'b1, ~e_be, e_wdata});
              rd_word = mem.exists(key) ? mem[key] : 16'h0;
              if (!dqm[0]) rd_word[7:0] = dq_o[7:0];
              if (!dqm[1]) rd_word[15:8] = dq_o[15:8];
              mem[key] = rd_word;
              wbeats = BURST_LEN - 1;
            end else begin
              rd_word = mem.exists(key) ? mem[key] : 16'h0;
              rd_cd = CAS_LAT;
              rd_t = cyc;
            end
          end
          default: chk(0, "R1", "unknown command", c, C_NOP);
        endcase
        last_cmd = c;
        last_t = cyc;
      end
      if (c != C_WR && wbeats > 0) begin
        chk(dq_oe && dqm == 2'b11, "R5", "masked tail beat", {dq_oe, dqm}, 3'b111);
        wbeats--;
      end
      if (rd_valid) begin
        chk(cyc - rd_t == CAS_LAT + 1, "R6", "read latency", cyc - rd_t, CAS_LAT + 1);
        if (exp_q.size() == 0) chk(0, "R6", "unexpected read data", rd_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R6", "read data", rd_data, e);
        end
      end
    end
  end

  task automatic host_op(input bit we, input logic [23:0] a, input logic [15:0] d,
                         input logic [1:0] be);
    logic [15:0] old;
    bit acc;
    req_we = we; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      acc = req_ready;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    old = shadow.exists(a) ? shadow[a] : 16'h0;
    if (we) shadow[a] = {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
    else exp_q.push_back(old);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [23:0] lfsr;
    int r0;
    repeat (4) begin
      @(negedge clk);
      chk({cs_n, ras_n, cas_n, we_n} == C_NOP && !req_ready && !rd_valid, "R1", "reset state",
          {cs_n, ras_n, cas_n, we_n, req_ready, rd_valid}, {C_NOP, 2'b00});
    end
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP && !req_ready, "R1", "power-up wait idle",
        {cs_n, ras_n, cas_n, we_n, req_ready}, {C_NOP, 1'b0});
    while (!req_ready) @(negedge clk);
    chk(init_idx == 4, "R2", "init complete before ready", init_idx, 4);
    @(posedge clk); #1;
    // full-word writes across all banks, then read back
    for (int b = 0; b < 4; b++) host_op(1, {2'(b), 13'h1A5 + 13'(b), 9'h0F0 + 9'(b)}, 16'h1100 * 16'(b + 1) + 16'h0033, 2'b11);
    for (int b = 0; b < 4; b++) host_op(0, {2'(b), 13'h1A5 + 13'(b), 9'h0F0 + 9'(b)}, 16'h0, 2'b00);
    // byte-masked writes: low only, high only, none
    host_op(1, 24'h3F_FFFF, 16'hAAAA, 2'b11);
    host_op(1, 24'h3F_FFFF, 16'h5512, 2'b01);
    host_op(0, 24'h3F_FFFF, 16'h0, 2'b00);
    host_op(1, 24'h3F_FFFF, 16'h34CC, 2'b10);
    host_op(0, 24'h3F_FFFF, 16'h0, 2'b00);
    host_op(1, 24'h3F_FFFF, 16'h7777, 2'b00);
    host_op(0, 24'h3F_FFFF, 16'h0, 2'b00);
    // neighbouring column untouched by masked tail beats
    host_op(1, 24'h00_0001, 16'h4242, 2'b11);
    host_op(1, 24'h00_0000, 16'h1357, 2'b11);
    host_op(0, 24'h00_0001, 16'h0, 2'b00);
    // continuous traffic across refresh intervals
    r0 = ref_cnt;
    lfsr = 24'h5A3C96;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      host_op(1, lfsr, {4'h6, lfsr[11:0]}, lfsr[13:12] | 2'b01);
      host_op(0, lfsr, 16'h0, 2'b00);
    end
    chk(ref_cnt - r0 >= 3, "R8", "refreshes under load", ref_cnt - r0, 3);
    // idle host
    r0 = ref_cnt;
    repeat (2500) @(posedge clk);
    chk(ref_cnt - r0 >= 2, "R7", "refreshes while idle", ref_cnt - r0, 2);
    repeat (50) @(posedge clk);
    chk(exp_q.size() == 0, "R6", "all reads returned", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule